// File: doc/BRIEF.md
# Isochronous IN Interval Flush Monitor

This block supervises one isochronous IN endpoint of a USB device controller. The host is meant to fetch data from the endpoint with an IN token at least once in every service interval. The interval is a programmed number of frames at full speed, or microframes at high speed. The block counts start-of-frame ticks since the last IN token. When a whole interval passes with no token, it reports an interval error. If flushing is enabled, it also tells the endpoint FIFO to discard stale data.

The discard is not issued when the miss is first known. It waits for the frame boundary that closes the (micro)frame in which the token was due. The block takes that boundary from decoded valid SOF events. If an SOF is corrupted or lost, an interpolator counts clock cycles and supplies a synthetic tick once the nominal frame period plus a tolerance has passed. In double-buffer operation the flush names the plane that was filled first, so the newer plane survives. The block takes decoded events and control levels as inputs, and it gives single-cycle strobes as outputs.

Top module: `iso_in_flush_mon`

## Requirements
- R1: While reset is high, and on the first clock after it, ival_err, flush_stb and flush_plane are 0. Reset clears the registered control copies, so flushing is disabled and the interval code is 0.
- R2: With interval code k (interval_sel, 0 to 7), the interval is N = 2^k frame ticks. With no IN token, the first error comes on the (N+1)th tick after the last token or after activation. Later errors then come every N ticks.
- R3: An IN token resets the tick count to zero. A token that arrives in the same cycle as a tick counts for the new frame and suppresses an error on that tick.
- R4: An error is a one-cycle pulse on ival_err. It appears in the clock after the tick edge that found the miss, and it appears whatever the flush setting.
- R5: flush_stb pulses in the same cycle as ival_err only if flush enable is 1. If flush enable is 0, no flush is issued.
- R6: Monitoring runs only while dev_mode and pipe_iso_in are both 1. Otherwise the count is held at zero and no error or flush appears, even with flush enable at 1. All three control inputs and interval_sel take effect one clock after they are sampled.
- R7: If no valid SOF arrives, a synthetic tick fires PERIOD_CYC+TOL_CYC cycles after the last SOF edge. Further synthetic ticks then fire every PERIOD_CYC cycles.
- R8: Each accepted valid SOF is a tick and re-aligns the interpolator, so the next synthetic tick is timed from that SOF.
- R9: A valid SOF that arrives no more than TOL_CYC+1 cycles after a synthetic tick is a late copy of that boundary. It re-aligns the interpolator but produces no extra tick.
- R10: flush_plane is 1 only during a flush with dbl_buf=1 and older_plane=1. Plane index 1 is flushed when older_plane is 1, and plane 0 in every other case, including single-buffer mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dev_mode | input | 1 | Controller is operating as a device |
| pipe_iso_in | input | 1 | Monitored pipe is isochronous with IN direction |
| flush_en | input | 1 | 1: flush the FIFO on an interval error |
| interval_sel | input | 3 | Interval code k, interval 2^k (micro)frames |
| dbl_buf | input | 1 | Endpoint uses two buffer planes |
| older_plane | input | 1 | Index of the plane filled earlier |
| sof_ok | input | 1 | One-cycle pulse: valid SOF received |
| in_token | input | 1 | One-cycle pulse: IN token received for this pipe |
| flush_stb | output | 1 | One-cycle FIFO clear request |
| flush_plane | output | 1 | Plane to clear, valid with flush_stb |
| ival_err | output | 1 | One-cycle interval error pulse |

## Verification
The bench aims at off-by-one counting: a design that errs on the Nth tick instead of the (N+1)th, or that lets a token arriving with a tick raise an error, gives the wrong pulse counts. It stops SOFs so that synthetic ticks must carry the count. It then inserts an early SOF, where a design that does not re-align fires a synthetic tick too soon. It also sends a late SOF just after a synthetic tick, where a design without absorption counts one frame twice. Further checks confirm that flushes vanish when flushing is off or the pipe is not an isochronous IN pipe, and that the plane index follows the double-buffer rule. Random traffic with jitter, dropped SOFs and changing control settings is compared cycle by cycle against a bench model.

// File: rtl/iif_pkg.sv
package iif_pkg;

    // Width of the interval code and of the tick counter that must hold 2^(2^IVAL_W-1).
    localparam int IVAL_W = 3;
    localparam int FCNT_W = 1 << IVAL_W;

    typedef enum logic [1:0] {
        TICK_NONE  = 2'd0,
        TICK_REAL  = 2'd1,
        TICK_SYNTH = 2'd2
    } tick_kind_e;

    typedef struct packed {
        logic              active;
        logic              flush_en;
        logic [IVAL_W-1:0] ival;
    } cfg_t;

    // Interval length in frame ticks for a given code.
    function automatic logic [FCNT_W-1:0] interval_frames(input logic [IVAL_W-1:0] code);
        return FCNT_W'(1) << code;
    endfunction

endpackage

// File: rtl/iif_sof_interp.sv
module iif_sof_interp
    import iif_pkg::*;
#(
    parameter int PERIOD_CYC = 25000,
    parameter int TOL_CYC    = 64
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sof_ok,
    output tick_kind_e tick_kind
);
    localparam int LATE = PERIOD_CYC - 1 + TOL_CYC;
    localparam int CW   = $clog2(LATE + 1);
    localparam logic [CW-1:0] LATE_C = CW'(LATE);
    localparam logic [CW-1:0] TOL_C  = CW'(TOL_CYC);

    logic [CW-1:0] cnt_q;
    logic          late_hit;
    logic          absorb;

    assign late_hit = (cnt_q == LATE_C);

    // Cycle counter since the last frame boundary reference.
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (sof_ok) begin
            cnt_q <= '0;
        end else if (late_hit) begin
            cnt_q <= TOL_C;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    generate
        if (TOL_CYC > 0) begin : g_guard
            localparam logic [CW-1:0] GEND_C = CW'(2 * TOL_CYC);
            logic guard_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    guard_q <= 1'b0;
                end else if (sof_ok) begin
                    guard_q <= 1'b0;
                end else if (late_hit) begin
                    guard_q <= 1'b1;
                end else if (cnt_q >= GEND_C) begin
                    guard_q <= 1'b0;
                end
            end
            assign absorb = guard_q && (cnt_q <= GEND_C);
        end else begin : g_noguard
            assign absorb = 1'b0;
        end
    endgenerate

    always_comb begin
        tick_kind = TICK_NONE;
        if (sof_ok) begin
            if (!absorb) tick_kind = TICK_REAL;
        end else if (late_hit) begin
            tick_kind = TICK_SYNTH;
        end
    end

endmodule

// File: rtl/iif_frame_watch.sv
module iif_frame_watch
    import iif_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              active,
    input  logic [IVAL_W-1:0] ival,
    input  logic              tick,
    input  logic              in_token,
    output logic              miss
);
    logic [FCNT_W-1:0] fcnt_q;
    logic [FCNT_W-1:0] span;

    assign span = interval_frames(ival);
    assign miss = active && tick && !in_token && (fcnt_q >= span);

    // Ticks since the last token or since the last reported miss.
    always_ff @(posedge clk) begin
        if (rst || !active || in_token) begin
            fcnt_q <= '0;
        end else if (tick) begin
            fcnt_q <= miss ? FCNT_W'(1) : fcnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/iif_flush_ctrl.sv
module iif_flush_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic miss,
    input  logic flush_en,
    input  logic dbl_buf,
    input  logic older_plane,
    output logic ival_err,
    output logic flush_stb,
    output logic flush_plane
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ival_err    <= 1'b0;
            flush_stb   <= 1'b0;
            flush_plane <= 1'b0;
        end else begin
            ival_err    <= miss;
            flush_stb   <= miss && flush_en;
            flush_plane <= miss && flush_en && dbl_buf && older_plane;
        end
    end

endmodule

// File: rtl/iso_in_flush_mon.sv
module iso_in_flush_mon
    import iif_pkg::*;
#(
    parameter int PERIOD_CYC = 25000,
    parameter int TOL_CYC    = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              dev_mode,
    input  logic              pipe_iso_in,
    input  logic              flush_en,
    input  logic [IVAL_W-1:0] interval_sel,
    input  logic              dbl_buf,
    input  logic              older_plane,
    input  logic              sof_ok,
    input  logic              in_token,
    output logic              flush_stb,
    output logic              flush_plane,
    output logic              ival_err
);
    cfg_t       cfg_q;
    tick_kind_e tick_kind;
    logic       tick_any;
    logic       miss;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else begin
            cfg_q.active   <= dev_mode && pipe_iso_in;
            cfg_q.flush_en <= flush_en;
            cfg_q.ival     <= interval_sel;
        end
    end

    iif_sof_interp #(
        .PERIOD_CYC(PERIOD_CYC),
        .TOL_CYC   (TOL_CYC)
    ) u_interp (
        .clk      (clk),
        .rst      (rst),
        .sof_ok   (sof_ok),
        .tick_kind(tick_kind)
    );

    assign tick_any = (tick_kind != TICK_NONE);

    iif_frame_watch u_watch (
        .clk     (clk),
        .rst     (rst),
        .active  (cfg_q.active),
        .ival    (cfg_q.ival),
        .tick    (tick_any),
        .in_token(in_token),
        .miss    (miss)
    );

    iif_flush_ctrl u_flush (
        .clk        (clk),
        .rst        (rst),
        .miss       (miss),
        .flush_en   (cfg_q.flush_en),
        .dbl_buf    (dbl_buf),
        .older_plane(older_plane),
        .ival_err   (ival_err),
        .flush_stb  (flush_stb),
        .flush_plane(flush_plane)
    );

endmodule

// File: rtl/iif_checker.sv
module iif_checker (
    input logic clk,
    input logic rst,
    input logic dev_mode,
    input logic pipe_iso_in,
    input logic flush_en,
    input logic dbl_buf,
    input logic older_plane,
    input logic tick_any,
    input logic ival_err,
    input logic flush_stb,
    input logic flush_plane
);
    assert_reset_quiet_R1: assert property (@(posedge clk)
        $past(rst) |-> (!ival_err && !flush_stb && !flush_plane));

    assert_err_follows_tick_R4: assert property (@(posedge clk) disable iff (rst)
        ival_err |-> $past(tick_any));

    assert_flush_with_err_R5: assert property (@(posedge clk) disable iff (rst)
        flush_stb |-> ival_err);

    assert_flush_enabled_R5: assert property (@(posedge clk) disable iff (rst)
        flush_stb |-> $past(flush_en, 2));

    assert_err_only_active_R6: assert property (@(posedge clk) disable iff (rst)
        ival_err |-> $past(dev_mode && pipe_iso_in, 2));

    assert_plane_rule_R10: assert property (@(posedge clk) disable iff (rst)
        flush_plane |-> (flush_stb && $past(dbl_buf && older_plane)));

endmodule

bind iso_in_flush_mon iif_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .dev_mode   (dev_mode),
    .pipe_iso_in(pipe_iso_in),
    .flush_en   (flush_en),
    .dbl_buf    (dbl_buf),
    .older_plane(older_plane),
    .tick_any   (tick_any),
    .ival_err   (ival_err),
    .flush_stb  (flush_stb),
    .flush_plane(flush_plane)
);

// File: tb/iso_in_flush_mon_bench.sv
module iso_in_flush_mon_bench;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int P    = 20;
    localparam int T    = 3;
    localparam int LATE = P - 1 + T;
    localparam int GEND = 2 * T;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       dev_mode = 1'b0;
    logic       pipe_iso_in = 1'b0;
    logic       flush_en = 1'b0;
    logic [2:0] interval_sel = 3'd0;
    logic       dbl_buf = 1'b0;
    logic       older_plane = 1'b0;
    logic       sof_ok = 1'b0;
    logic       in_token = 1'b0;
    logic       flush_stb;
    logic       flush_plane;
    logic       ival_err;

    always #2.5 clk = ~clk;

    iso_in_flush_mon #(.PERIOD_CYC(P), .TOL_CYC(T)) u_iso_in_flush_mon (
        .clk(clk), .rst(rst), .dev_mode(dev_mode), .pipe_iso_in(pipe_iso_in),
        .flush_en(flush_en), .interval_sel(interval_sel), .dbl_buf(dbl_buf),
        .older_plane(older_plane), .sof_ok(sof_ok), .in_token(in_token),
        .flush_stb(flush_stb), .flush_plane(flush_plane), .ival_err(ival_err)
    );

    int checks = 0;
    int errors = 0;
    int n_err = 0, n_stb = 0, n_pl1 = 0;

    // Reference model built from the requirements, stepped on each rising edge.
    int m_cnt = 0, m_f = 0, m_iv = 0;
    bit m_guard = 0, m_act = 0, m_fe = 0;
    bit e_err = 0, e_stb = 0, e_pl = 0;
    bit r_tick = 0, r_miss = 0;

    always @(posedge clk) begin
        if (rst) begin
            m_cnt = 0; m_guard = 0; m_f = 0; m_act = 0; m_fe = 0; m_iv = 0;
            e_err = 0; e_stb = 0; e_pl = 0;
        end else begin
            r_tick = (sof_ok && !(m_guard && m_cnt <= GEND)) || (!sof_ok && m_cnt == LATE);
            if (sof_ok) begin
                m_cnt = 0; m_guard = 0;
            end else if (m_cnt == LATE) begin
                m_cnt = T; m_guard = 1;
            end else begin
                if (m_cnt >= GEND) m_guard = 0;
                m_cnt = m_cnt + 1;
            end
            r_miss = m_act && r_tick && !in_token && (m_f >= (1 << m_iv));
            if (!m_act || in_token) m_f = 0;
            else if (r_tick) m_f = r_miss ? 1 : m_f + 1;
            e_err = r_miss;
            e_stb = r_miss && m_fe;
            e_pl  = r_miss && m_fe && dbl_buf && older_plane;
            m_act = dev_mode && pipe_iso_in;
            m_fe  = flush_en;
            m_iv  = int'(interval_sel);
        end
    end

    task automatic cyc(input bit s, input bit t);
        @(negedge clk);
        checks++;
        if (ival_err !== e_err) begin
            errors++;
            $display("FAIL %s ival_err got %0b exp %0b at %0t", rst ? "R1" : "R4", ival_err, e_err, $time);
        end
        if (flush_stb !== e_stb) begin
            errors++;
            $display("FAIL %s flush_stb got %0b exp %0b at %0t", rst ? "R1" : "R5", flush_stb, e_stb, $time);
        end
        if (flush_plane !== e_pl) begin
            errors++;
            $display("FAIL %s flush_plane got %0b exp %0b at %0t", rst ? "R1" : "R10", flush_plane, e_pl, $time);
        end
        n_err += int'(ival_err);
        n_stb += int'(flush_stb);
        n_pl1 += int'(flush_plane);
        sof_ok   = s;
        in_token = t;
    endtask

    task automatic idle(input int n);
        repeat (n) cyc(1'b0, 1'b0);
    endtask

    task automatic sofs(input int n, input bit tok);
        repeat (n) begin
            idle(P - 1);
            cyc(1'b1, tok);
        end
    endtask

    task automatic zero();
        n_err = 0; n_stb = 0; n_pl1 = 0;
    endtask

    task automatic expect_count(input string tag, input string what, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s count got %0d exp %0d", tag, what, got, exp);
        end
    endtask

    task automatic setcfg(input bit d, input bit i, input bit f, input int sel, input bit db, input bit op);
        @(negedge clk);
        dev_mode = d; pipe_iso_in = i; flush_en = f; interval_sel = 3'(sel);
        dbl_buf = db; older_plane = op;
        idle(2);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors + 1);
        $finish;
    end

    initial begin
        int gap, target;
        bit s, t;
        void'($urandom(32'd1234));

        // R1: reset state
        idle(4);
        rst = 1'b0;
        zero();
        idle(60);
        expect_count("R1", "err after reset", n_err, 0);

        // R2 and R5: N=4, one token, 13 real SOFs -> errors on ticks 5, 9, 13
        setcfg(1, 1, 1, 2, 0, 0);
        cyc(1, 1);
        zero(); sofs(13, 0); idle(2);
        expect_count("R2", "err", n_err, 3);
        expect_count("R5", "flush", n_stb, 3);

        // R3: token arriving with each tick, N=1 -> no error
        setcfg(1, 1, 1, 0, 0, 0);
        cyc(1, 1);
        zero(); sofs(8, 1); idle(2);
        expect_count("R3", "err", n_err, 0);
        zero(); sofs(4, 0); idle(2);
        expect_count("R2", "err N=1", n_err, 3);

        // R4/R5: flushing disabled still reports errors
        setcfg(1, 1, 0, 0, 0, 0);
        cyc(1, 1);
        zero(); sofs(5, 0); idle(2);
        expect_count("R4", "err", n_err, 4);
        expect_count("R5", "flush disabled", n_stb, 0);

        // R6: inactive pipe or host mode
        setcfg(1, 0, 1, 0, 0, 0);
        cyc(1, 1);
        zero(); sofs(5, 0); idle(2);
        expect_count("R6", "err non-iso", n_err + n_stb, 0);
        setcfg(0, 1, 1, 0, 0, 0);
        cyc(1, 1);
        zero(); sofs(5, 0); idle(2);
        expect_count("R6", "err host mode", n_err + n_stb, 0);

        // R10: plane selection
        setcfg(1, 1, 1, 0, 1, 1);
        cyc(1, 1);
        zero(); sofs(4, 0); idle(2);
        expect_count("R10", "plane1 dbl", n_pl1, 3);
        setcfg(1, 1, 1, 0, 1, 0);
        cyc(1, 1);
        zero(); sofs(4, 0); idle(2);
        expect_count("R10", "plane1 older0", n_pl1, 0);
        expect_count("R10", "flush older0", n_stb, 3);
        setcfg(1, 1, 1, 0, 0, 1);
        cyc(1, 1);
        zero(); sofs(4, 0); idle(2);
        expect_count("R10", "plane1 single", n_pl1, 0);

        // R7: no SOF at all -> synthetic ticks at 23, 43, 63, 83
        setcfg(1, 1, 1, 0, 0, 0);
        cyc(1, 1);
        zero(); idle(LATE + 1 + 3 * P); idle(2);
        expect_count("R7", "err synthetic", n_err, 3);

        // R9: late SOF two cycles after a synthetic tick is absorbed
        cyc(1, 1);
        zero(); idle(LATE + 1); idle(1); cyc(1, 0); idle(P - 1); cyc(1, 0); idle(2);
        expect_count("R9", "err late sof", n_err, 1);

        // R8: early SOF re-aligns the interpolator
        cyc(1, 1);
        zero(); idle(9); cyc(1, 0); idle(20);
        expect_count("R8", "err before realigned tick", n_err, 0);
        idle(5);
        expect_count("R8", "err at realigned tick", n_err, 1);

        // Random traffic, all requirements against the model
        gap = 0; target = P;
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(199) == 0) begin
                dev_mode     = ($urandom_range(4) != 0);
                pipe_iso_in  = ($urandom_range(4) != 0);
                flush_en     = 1'($urandom_range(1));
                interval_sel = 3'($urandom_range(3));
            end
            dbl_buf     = 1'($urandom_range(1));
            older_plane = 1'($urandom_range(1));
            s = 1'b0;
            gap++;
            if (gap >= target) begin
                gap = 0;
                target = $urandom_range(P - 3, P + 6);
                s = ($urandom_range(7) != 0);
            end
            t = ($urandom_range(24) == 0);
            cyc(s, t);
        end
        idle(3);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule